// File: doc/BRIEF.md
# Eight-Channel 12-Bit Converter Serial Slave

This block is the digital front of an eight-input, 12-bit successive-approximation converter that a host reads over a four-wire serial port: an active-low select, a serial clock, a data input and a data output. The serial pins are resampled by a fast system clock, which must run at least four times faster than the serial clock. Every edge decision is taken on the resampled levels. Eight parallel 12-bit sample buses stand in for the analog inputs.

A frame opens when select falls and closes when it rises. A frame carries one or more 16-clock conversions back to back. In each conversion the host writes an 8-bit control byte whose address field chooses the input for the *following* conversion. Meanwhile the block returns four zero bits and then the 12-bit straight-binary result, most significant bit first. Two status outputs mark the track phase and the power-down state, which a system can use to sequence an analog model or to gate power.

Top module: `adc_serial_slave`

## Requirements
- R1: After reset and whenever select is high, `dout_oe` is 0, `pwr_down` is 1 and `track` is 0; `dout_oe` is 1 only while select is low.
- R2: Each conversion returns 16 bits, one per serial falling edge; the bits returned at falling edges 1 to 4 are 0. The output settles no more than 3 system clocks after the edge.
- R3: Control bits are taken from `din` at the first 8 rising edges of each conversion, bit 7 first. The channel number is bits 5:3 as an unsigned value, from 000 for channel 0 to 111 for channel 7. Bits 7, 6, 2, 1 and 0 have no effect. At falling edges 5 to 16, the next conversion returns the chosen channel's sample as bits 11 down to 0.
- R4: The first conversion after reset returns channel 0. The chosen channel is kept across frames until a later control byte replaces it.
- R5: `track` is 1 from the 1st through the 3rd falling edge of each conversion and 0 from the 4th falling edge on.
- R6: `pwr_down` is 1 from the 16th falling edge of a conversion until the 1st falling edge of the next, as well as while select is high.
- R7: When select falls while the serial clock is low, that select edge counts as falling edge 1. When select falls while the serial clock is high, falling edge 1 is the next serial clock fall.
- R8: A frame of N times 16 clocks yields N conversions. Each new conversion starts at the falling edge that follows the 16th rising edge.
- R9: The sample is captured at falling edge 4. Changes on the sample inputs after that edge do not alter the value being returned.
- R10: Serial clock edges while select is high have no effect: the outputs stay at their idle values, and the next frame counts from its own first falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Serial select, active low, asynchronous to clk |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial control data, sampled on rising serial edges |
| samples_i | input | 96 | Eight 12-bit samples, channel k at bits 12k+11:12k |
| dout | output | 1 | Serial result data, changes after serial falling edges |
| dout_oe | output | 1 | Output enable for dout (high impedance when 0) |
| track | output | 1 | High during the track phase |
| pwr_down | output | 1 | High while the converter may power down |

## Verification
Suppose the falling-edge counter drifts by a single count. Then `track` and `pwr_down` move by one serial cycle within that conversion, and the 12-bit word read back comes out shifted or missing a bit within the same 16 clocks. A wrong held channel or a wrong address capture stays hidden until the conversion after the control byte. At that point the whole returned word belongs to another input, so the sweep gives every channel a distinct value. A sample register that follows its input instead of holding shows up only when a sample changes mid-conversion, and one dedicated pattern provokes that.

// File: rtl/adc_slave_pkg.sv
// Package: shared types for the serial converter slave.
// Assumes nothing beyond IEEE 1800-2017.
package adc_slave_pkg;

    // Phase of the current conversion as seen from the pins.
    typedef enum logic [1:0] {
        PH_SLEEP = 2'd0,   // select high, or between conversions
        PH_WAIT  = 2'd1,   // select low, first serial fall not seen yet
        PH_TRACK = 2'd2,   // sampling window
        PH_CONV  = 2'd3    // hold / conversion with data going out
    } phase_e;

endpackage

// File: rtl/pin_sync.sv
// Module: pin_sync
// Resamples a vector of asynchronous pins into the clk domain through
// STAGES flops per bit. Assumes the pins stay stable for several clk
// periods so that all bits of one pin change are seen together.
module pin_sync #(
    parameter int              W       = 3,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] level_o
);

    logic [STAGES-1:0][W-1:0] stage_q;

    // Shift the pin values through the resampling chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= {STAGES{RST_VAL}};
        end else begin
            for (int s = STAGES - 1; s > 0; s--) begin
                stage_q[s] <= stage_q[s-1];
            end
            stage_q[0] <= pin_i;
        end
    end

    assign level_o = stage_q[STAGES-1];

endmodule

// File: rtl/conv_seq.sv
// Module: conv_seq
// Detects serial clock and select edges on resampled levels, counts the
// falling and rising edges of each 16-clock conversion and derives the
// phase. Assumes clk runs at least 4x the serial clock and that a legal
// frame holds a whole number of conversions.
module conv_seq
    import adc_slave_pkg::*;
#(
    parameter int FRAME_LEN = 16,
    parameter int TRACK_LEN = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              sclk_lvl_i,
    input  logic                              cs_lvl_i,
    output logic                              active_o,
    output logic                              start_o,
    output logic                              fall_ev_o,
    output logic [$clog2(FRAME_LEN+1)-1:0]    fall_pos_o,
    output logic                              rise_ev_o,
    output logic [$clog2(FRAME_LEN+1)-1:0]    rise_idx_o,
    output phase_e                            phase_o
);

    localparam int CNT_W = $clog2(FRAME_LEN + 1);
    localparam logic [CNT_W-1:0] LAST_FALL = CNT_W'(FRAME_LEN);
    localparam logic [CNT_W-1:0] LAST_RISE = CNT_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0] TRK_END   = CNT_W'(TRACK_LEN);
    localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

    logic             sclk_prev, cs_prev;
    logic             sclk_rise, sclk_fall;
    logic [CNT_W-1:0] fall_cnt, rise_cnt, fall_nxt;

    // Keep last resampled levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
            cs_prev   <= 1'b1;
        end else begin
            sclk_prev <= sclk_lvl_i;
            cs_prev   <= cs_lvl_i;
        end
    end

    assign sclk_rise = sclk_lvl_i & ~sclk_prev;
    assign sclk_fall = ~sclk_lvl_i & sclk_prev;
    assign active_o  = ~cs_lvl_i;
    assign start_o   = active_o & cs_prev;

    // A select fall with the clock low stands in for falling edge 1.
    assign fall_ev_o = start_o ? ~sclk_lvl_i : (active_o & sclk_fall);
    assign rise_ev_o = active_o & ~start_o & sclk_rise;

    // Position the current falling edge takes within its conversion.
    always_comb begin
        if (start_o || fall_cnt == LAST_FALL) fall_nxt = ONE;
        else                                  fall_nxt = fall_cnt + ONE;
    end
    assign fall_pos_o = fall_nxt;
    assign rise_idx_o = rise_cnt;

    // Falling-edge position counter, cleared at every frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fall_cnt <= '0;
        end else if (start_o) begin
            fall_cnt <= sclk_lvl_i ? '0 : ONE;
        end else if (fall_ev_o) begin
            fall_cnt <= fall_nxt;
        end
    end

    // Rising-edge counter, modulo one conversion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_cnt <= '0;
        end else if (start_o) begin
            rise_cnt <= '0;
        end else if (rise_ev_o) begin
            rise_cnt <= (rise_cnt == LAST_RISE) ? '0 : rise_cnt + ONE;
        end
    end

    // Phase decode from select level and falling-edge position.
    always_comb begin
        if (!active_o)                phase_o = PH_SLEEP;
        else if (start_o)             phase_o = PH_WAIT;
        else if (fall_cnt == '0)      phase_o = PH_WAIT;
        else if (fall_cnt <= TRK_END) phase_o = PH_TRACK;
        else if (fall_cnt == LAST_FALL) phase_o = PH_SLEEP;
        else                          phase_o = PH_CONV;
    end

    // R7: select falling with the clock low opens the track window at once.
    assert_cs_low_clk_tracks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o && !sclk_lvl_i) |=> (phase_o == PH_TRACK || !active_o));

    // R7: select falling with the clock high waits for the next fall.
    assert_cs_high_clk_waits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o && sclk_lvl_i) |=> (phase_o != PH_TRACK));

    // R5: the fall after the last track cycle leaves the track phase.
    assert_track_closes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_ev_o && !start_o && fall_cnt == TRK_END) |=> (phase_o != PH_TRACK));

    // R6: the 16th fall of a conversion enters power-down.
    assert_last_fall_sleeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_ev_o && !start_o && fall_cnt == LAST_FALL - ONE && active_o)
        |=> (phase_o == PH_SLEEP));

    // R8: the fall after a complete conversion begins the next one.
    assert_conv_wraps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_ev_o && !start_o && fall_cnt == LAST_FALL) |=> (fall_cnt == ONE));

    // R10: nothing counts while select is high.
    assert_idle_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !active_o |=> ($stable(fall_cnt) && $stable(rise_cnt)));

endmodule

// File: rtl/ctrl_shift.sv
// Module: ctrl_shift
// Collects the control byte from the first CTRL_BITS rising edges of a
// conversion and updates the channel used by the next conversion. Only
// the bits up to the top of the address field are stored; the bits
// above it are discarded as they arrive.
module ctrl_shift #(
    parameter int NUM_CH    = 8,
    parameter int CTRL_BITS = 8,
    parameter int ADDR_LSB  = 3,
    parameter int FRAME_LEN = 16,
    parameter int RST_CHAN  = 0
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              rise_ev_i,
    input  logic [$clog2(FRAME_LEN+1)-1:0]    rise_idx_i,
    input  logic                              din_i,
    output logic [$clog2(NUM_CH)-1:0]         sel_ch_o
);

    localparam int CH_W  = $clog2(NUM_CH);
    localparam int CNT_W = $clog2(FRAME_LEN + 1);
    localparam int SH_W  = ADDR_LSB + CH_W - 1;
    localparam logic [CNT_W-1:0] LAST_CTRL = CNT_W'(CTRL_BITS - 1);
    localparam logic [CNT_W-1:0] NUM_CTRL  = CNT_W'(CTRL_BITS);

    logic [SH_W-1:0] shreg;
    logic            last_bit;

    assign last_bit = rise_ev_i && (rise_idx_i == LAST_CTRL);

    // Shift control bits in while inside the control window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (rise_ev_i && rise_idx_i < NUM_CTRL) begin
            shreg <= {shreg[SH_W-2:0], din_i};
        end
    end

    // Take the address field when the last control bit arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_ch_o <= CH_W'(RST_CHAN);
        end else if (last_bit) begin
            sel_ch_o <= shreg[ADDR_LSB-1 +: CH_W];
        end
    end

    // R3: the channel register only moves on the last control bit.
    assert_sel_only_on_last_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !last_bit |=> $stable(sel_ch_o));

endmodule

// File: rtl/result_shift.sv
// Module: result_shift
// Captures the selected sample at the end of the track window and drives
// the serial result: leading zeros, then the sample MSB first, one bit
// per falling edge. Assumes the capture point lies within the zero
// prefix (TRACK_LEN + 1 <= FRAME_LEN - RES_BITS).
module result_shift #(
    parameter int NUM_CH    = 8,
    parameter int RES_BITS  = 12,
    parameter int FRAME_LEN = 16,
    parameter int TRACK_LEN = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start_i,
    input  logic                              fall_ev_i,
    input  logic [$clog2(FRAME_LEN+1)-1:0]    fall_pos_i,
    input  logic [$clog2(NUM_CH)-1:0]         sel_ch_i,
    input  logic [NUM_CH*RES_BITS-1:0]        samples_i,
    output logic                              dout_o
);

    localparam int CNT_W = $clog2(FRAME_LEN + 1);
    localparam logic [CNT_W-1:0] LEAD_END  = CNT_W'(FRAME_LEN - RES_BITS);
    localparam logic [CNT_W-1:0] LATCH_POS = CNT_W'(TRACK_LEN + 1);

    logic [RES_BITS-1:0] smp [NUM_CH];
    logic [RES_BITS-1:0] picked;
    logic [RES_BITS-1:0] out_sh;
    logic                latch_now;

    // Split the flat sample bus into one word per channel.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_unpack
        assign smp[g] = samples_i[g*RES_BITS +: RES_BITS];
    end

    assign picked    = smp[sel_ch_i];
    assign latch_now = fall_ev_i && (fall_pos_i == LATCH_POS);

    // Hold the captured sample and shift it out after the zero prefix.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_sh <= '0;
        end else if (latch_now) begin
            out_sh <= picked;
        end else if (fall_ev_i && fall_pos_i > LEAD_END) begin
            out_sh <= {out_sh[RES_BITS-2:0], 1'b0};
        end
    end

    // Serial output bit, updated on each counted falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_o <= 1'b0;
        end else if (fall_ev_i) begin
            dout_o <= (fall_pos_i <= LEAD_END) ? 1'b0 : out_sh[RES_BITS-1];
        end else if (start_i) begin
            dout_o <= 1'b0;
        end
    end

    // R2: the first falling edges of a conversion always send zero.
    assert_lead_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_ev_i && fall_pos_i <= LEAD_END) |=> !dout_o);

    // R9: the captured word changes only on counted falling edges.
    assert_word_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_ev_i |=> $stable(out_sh));

endmodule

// File: rtl/adc_serial_slave.sv
// Module: adc_serial_slave (top)
// Serial slave side of an eight-input 12-bit converter: resamples the
// pins, sequences the conversion phases, takes the channel address and
// returns the selected sample. Assumes clk is at least 4x sclk and that
// all pins are asynchronous to clk.
module adc_serial_slave
    import adc_slave_pkg::*;
#(
    parameter int NUM_CH      = 8,
    parameter int RES_BITS    = 12,
    parameter int FRAME_LEN   = 16,
    parameter int TRACK_LEN   = 3,
    parameter int CTRL_BITS   = 8,
    parameter int ADDR_LSB    = 3,
    parameter int SYNC_STAGES = 2,
    parameter int RST_CHAN    = 0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cs_n,
    input  logic                       sclk,
    input  logic                       din,
    input  logic [NUM_CH*RES_BITS-1:0] samples_i,
    output logic                       dout,
    output logic                       dout_oe,
    output logic                       track,
    output logic                       pwr_down
);

    localparam int CH_W  = $clog2(NUM_CH);
    localparam int CNT_W = $clog2(FRAME_LEN + 1);

    logic [2:0]       pin_lvl;
    logic             active, start, fall_ev, rise_ev;
    logic [CNT_W-1:0] fall_pos, rise_idx;
    logic [CH_W-1:0]  sel_ch;
    phase_e           phase;

    pin_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) i_pin_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   ({cs_n, sclk, din}),
        .level_o (pin_lvl)
    );

    conv_seq #(
        .FRAME_LEN (FRAME_LEN),
        .TRACK_LEN (TRACK_LEN)
    ) i_conv_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_lvl_i (pin_lvl[1]),
        .cs_lvl_i   (pin_lvl[2]),
        .active_o   (active),
        .start_o    (start),
        .fall_ev_o  (fall_ev),
        .fall_pos_o (fall_pos),
        .rise_ev_o  (rise_ev),
        .rise_idx_o (rise_idx),
        .phase_o    (phase)
    );

    ctrl_shift #(
        .NUM_CH    (NUM_CH),
        .CTRL_BITS (CTRL_BITS),
        .ADDR_LSB  (ADDR_LSB),
        .FRAME_LEN (FRAME_LEN),
        .RST_CHAN  (RST_CHAN)
    ) i_ctrl_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_ev_i  (rise_ev),
        .rise_idx_i (rise_idx),
        .din_i      (pin_lvl[0]),
        .sel_ch_o   (sel_ch)
    );

    result_shift #(
        .NUM_CH    (NUM_CH),
        .RES_BITS  (RES_BITS),
        .FRAME_LEN (FRAME_LEN),
        .TRACK_LEN (TRACK_LEN)
    ) i_result_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .fall_ev_i  (fall_ev),
        .fall_pos_i (fall_pos),
        .sel_ch_i   (sel_ch),
        .samples_i  (samples_i),
        .dout_o     (dout)
    );

    assign dout_oe  = active;
    assign track    = (phase == PH_TRACK);
    assign pwr_down = (phase == PH_SLEEP);

    // R1: while select is high the block reports power-down and no tracking.
    assert_idle_outputs_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe |-> (pwr_down && !track));

endmodule

// File: tb/test_adc_serial_slave.sv
// Bench: drives the slave as a serial master in both clock idle levels,
// sweeps every channel and boundary sample values, and checks the
// returned words, phase flags and idle behaviour.
module test_adc_serial_slave;

    localparam int HALF = 8;   // system clocks per serial half period

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        din = 1'b0;
    logic [95:0] samples;
    logic        dout, dout_oe, track, pwr_down;

    logic [11:0] smp [8];
    logic [7:0]  ctrl_q [16];
    int          exp_ch = 0;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    always_comb begin
        for (int i = 0; i < 8; i++) samples[i*12 +: 12] = smp[i];
    end

    adc_serial_slave i_adc_serial_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .din       (din),
        .samples_i (samples),
        .dout      (dout),
        .dout_oe   (dout_oe),
        .track     (track),
        .pwr_down  (pwr_down)
    );

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic chk_idle(input string req);
        chk(req, "dout_oe idle", 16'(dout_oe), 16'd0);
        chk(req, "pwr_down idle", 16'(pwr_down), 16'd1);
        chk(req, "track idle", 16'(track), 16'd0);
    endtask

    // One frame of nconv conversions using ctrl_q; mut >= 0 changes the
    // sample under conversion number mut after its capture point.
    task automatic run_frame(input int nconv, input bit idle_high,
                             input int mut, input string wtag);
        logic [11:0] exp_word;
        logic [15:0] rx;
        sclk = idle_high;
        repeat (4) @(negedge clk);
        cs_n = 1'b0;
        for (int j = 1; j <= 16 * nconv; j++) begin
            int c = (j - 1) / 16;
            int p = (j - 1) % 16 + 1;
            if (!(j == 1 && !idle_high)) sclk = 1'b0;
            din = (p <= 8) ? ctrl_q[c][8 - p] : 1'b1;
            if (p == 1) begin
                exp_word = smp[exp_ch];
                rx = '0;
            end
            repeat (HALF) @(negedge clk);
            if (p == 6 && c == mut) smp[exp_ch] = ~smp[exp_ch];
            rx = {rx[14:0], dout};
            chk("R1", "dout_oe in frame", 16'(dout_oe), 16'd1);
            if (p <= 4) chk("R2", "leading zero", 16'(dout), 16'd0);
            chk((j == 1) ? "R7" : "R5", "track flag", 16'(track), 16'(p <= 3));
            chk("R6", "pwr_down flag", 16'(pwr_down), 16'(p == 16));
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            if (p == 16) begin
                chk(wtag, "returned word", rx, {4'h0, exp_word});
                exp_ch = int'(ctrl_q[c][5:3]);
            end
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (12) @(negedge clk);
        sclk = idle_high;
        repeat (8) @(negedge clk);
        chk_idle("R1");
    endtask

    task automatic fill_samples(input int seed);
        for (int i = 0; i < 8; i++) smp[i] = 12'((seed * 8 + i) * 293 + seed * 1111 + 5);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL R8 watchdog: actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        fill_samples(1);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        chk_idle("R1");

        // First conversion after reset returns channel 0, selects 5 next.
        ctrl_q[0] = 8'b00_101_000;
        run_frame(1, 1'b1, -1, "R4");
        // Channel 5 kept across frames; don't-care bits all set.
        ctrl_q[0] = 8'b11_010_111;
        run_frame(1, 1'b0, -1, "R4");

        // Continuous frame of eight conversions, clock idle low.
        fill_samples(2);
        for (int k = 0; k < 8; k++) ctrl_q[k] = {2'(k), 3'(7 - k), 3'(k * 3)};
        run_frame(8, 1'b0, -1, "R8");

        // Sweep every channel in both idle levels with varied bit patterns.
        for (int m = 0; m < 2; m++) begin
            for (int ch = 0; ch < 8; ch++) begin
                fill_samples(ch + 3 + m * 8);
                if (ch == 0) for (int i = 0; i < 8; i++) smp[i] = 12'hFFF;
                if (ch == 7) for (int i = 0; i < 8; i++) smp[i] = 12'h000;
                if (ch == 3) smp[exp_ch] = 12'h800;
                if (ch == 4) smp[exp_ch] = 12'h001;
                ctrl_q[0] = {2'(ch + m), 3'(ch), 3'(~ch)};
                ctrl_q[1] = {~2'(ch), 3'(7 - ch), 3'(ch)};
                run_frame(2, m[0], -1, "R3");
            end
        end

        // Serial clock toggles while select is high are ignored.
        for (int t = 0; t < 20; t++) begin
            sclk = ~sclk;
            repeat (HALF) @(negedge clk);
            chk_idle("R10");
        end
        fill_samples(30);
        ctrl_q[0] = 8'b01_110_010;
        run_frame(1, 1'b1, -1, "R10");

        // Sample changes after the capture point do not reach the output.
        fill_samples(31);
        ctrl_q[0] = 8'b00_001_000;
        ctrl_q[1] = 8'b10_100_001;
        ctrl_q[2] = 8'b00_011_100;
        run_frame(3, 1'b0, 1, "R9");
        run_frame(1, 1'b1, 0, "R9");

        done = 1'b1;
        finish_run();
    end

endmodule